// File: doc/BRIEF.md
# Pause Flow Control Resolver

Once the link partner's abilities are known, this block settles which direction of pause-frame flow control the MAC uses. On a resolve strobe it takes the local and partner pause and asymmetric-direction ability bits, the mode software asked for, and the negotiated duplex. It then registers the resolved two-bit mode, the transmit-pause and receive-pause enables, and the receive-buffer watermark thresholds that drive pause generation.

When auto-negotiation is disabled, the requested mode code is applied directly as a forced mode. A code outside the defined set raises a sticky configuration error and leaves the outputs untouched. Reading the PHY over its management interface and building pause frames are done elsewhere.

Top module: `pause_fc_resolver`

## Requirements
- R1: The mode encoding is 0 none, 1 receive-only, 2 transmit-only and 3 full. `tx_pause_en_o` equals bit 1 of `mode_o` and `rx_pause_en_o` equals bit 0.
- R2: With auto-negotiation, when both local pause and partner pause are set, the result is full if the requested code is 3 (full) or 4 (default). For any other requested code the result is receive-only.
- R3: With auto-negotiation, local pause 0, local asymmetric 1, partner pause 1 and partner asymmetric 1 resolve to transmit-only.
- R4: With auto-negotiation, local pause 1, local asymmetric 1, partner pause 0 and partner asymmetric 1 resolve to receive-only.
- R5: With auto-negotiation, every ability combination not covered by R2 to R4 resolves to none.
- R6: When `full_duplex_i` is 0 at the strobe, an applied result is none, whatever the ability bits or forced code say.
- R7: A strobe with auto-negotiation enabled but `an_complete_i` low changes no output other than `done_o`.
- R8: With auto-negotiation disabled, requested codes 0 to 3 are applied as the mode, and code 4 (default) is applied as full.
- R9: With auto-negotiation disabled, requested codes 5 to 7 set `cfg_err_o`, which stays high until reset. The mode, enables and watermarks keep their values.
- R10: Outputs change only on the clock edge that samples `resolve_i` high. `done_o` is high for exactly the cycle after each strobe.
- R11: When the applied mode includes transmit pause (2 or 3), the watermark outputs take `low_water_i`, `high_water_i` and `send_xon_i`. Otherwise all three are zero.
- R12: After reset, the mode, both enables, `done_o`, `cfg_err_o` and all watermark outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resolve_i | input | 1 | Strobe: evaluate and apply on this edge |
| an_enable_i | input | 1 | 1 selects negotiated resolution, 0 selects forced mode |
| an_complete_i | input | 1 | Auto-negotiation complete status |
| loc_pause_i | input | 1 | Local symmetric pause ability |
| loc_asym_i | input | 1 | Local asymmetric direction ability |
| lp_pause_i | input | 1 | Partner symmetric pause ability |
| lp_asym_i | input | 1 | Partner asymmetric direction ability |
| req_mode_i | input | 3 | Requested mode: 0..3 as R1, 4 default, 5..7 invalid |
| full_duplex_i | input | 1 | Negotiated duplex, 1 = full |
| low_water_i | input | WM_W | Low watermark to apply |
| high_water_i | input | WM_W | High watermark to apply |
| send_xon_i | input | 1 | XON transmission request |
| mode_o | output | 2 | Resolved mode |
| tx_pause_en_o | output | 1 | Transmit pause enable |
| rx_pause_en_o | output | 1 | Receive pause enable |
| low_thr_o | output | WM_W | Applied low watermark |
| high_thr_o | output | WM_W | Applied high watermark |
| xon_en_o | output | 1 | Applied XON enable |
| done_o | output | 1 | One-cycle pulse after each strobe |
| cfg_err_o | output | 1 | Sticky invalid forced-mode flag |

## Verification
A wrong entry in the resolution table shows on `mode_o` and the enables in the cycle right after the strobe. A stale or mis-gated mode register shows as a change on a cycle with no strobe, or on a strobe that should have been ignored. Watermarks that do not follow the mode show as nonzero thresholds beside a mode without transmit pause, visible on the same cycle. An error flag that fails to hold becomes visible at the next strobe after an invalid code.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int REQ_W = 3;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_RX   = 2'd1,
    FC_TX   = 2'd2,
    FC_FULL = 2'd3
  } fc_mode_e;
  localparam logic [REQ_W-1:0] REQ_FULL = 3'd3;
  localparam logic [REQ_W-1:0] REQ_DFLT = 3'd4;
endpackage

// File: rtl/fcr_negotiate.sv
module fcr_negotiate
  import fcr_pkg::*;
(
  input  logic     loc_pause_i,
  input  logic     loc_asym_i,
  input  logic     lp_pause_i,
  input  logic     lp_asym_i,
  input  logic     want_full_i,
  output fc_mode_e mode_o
);
  always_comb begin
    if (loc_pause_i && lp_pause_i)
      mode_o = want_full_i ? FC_FULL : FC_RX;
    else if (!loc_pause_i && loc_asym_i && lp_pause_i && lp_asym_i)
      mode_o = FC_TX;
    else if (loc_pause_i && loc_asym_i && !lp_pause_i && lp_asym_i)
      mode_o = FC_RX;
    else
      mode_o = FC_NONE;
  end
endmodule

// File: rtl/fcr_force_decode.sv
module fcr_force_decode
  import fcr_pkg::*;
(
  input  logic [REQ_W-1:0] req_i,
  output fc_mode_e         mode_o,
  output logic             bad_o
);
  always_comb begin
    bad_o  = 1'b0;
    mode_o = FC_NONE;
    if (req_i == REQ_DFLT)      mode_o = FC_FULL;
    else if (req_i <= REQ_FULL) mode_o = fc_mode_e'(req_i[1:0]);
    else                        bad_o  = 1'b1;
  end
endmodule

// File: rtl/fcr_state.sv
module fcr_state
  import fcr_pkg::*;
#(
  parameter int WM_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            strobe_i,
  input  logic            apply_i,
  input  logic            err_set_i,
  input  fc_mode_e        mode_i,
  input  logic [WM_W-1:0] low_i,
  input  logic [WM_W-1:0] high_i,
  input  logic            xon_i,
  output fc_mode_e        mode_o,
  output logic            tx_en_o,
  output logic            rx_en_o,
  output logic [WM_W-1:0] low_o,
  output logic [WM_W-1:0] high_o,
  output logic            xon_o,
  output logic            done_o,
  output logic            err_o
);
  logic tx_sel;
  assign tx_sel = (mode_i == FC_TX) || (mode_i == FC_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= FC_NONE;
      tx_en_o <= 1'b0;
      rx_en_o <= 1'b0;
      low_o   <= '0;
      high_o  <= '0;
      xon_o   <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= strobe_i;
      if (err_set_i) err_o <= 1'b1;
      if (apply_i) begin
        mode_o  <= mode_i;
        tx_en_o <= tx_sel;
        rx_en_o <= (mode_i == FC_RX) || (mode_i == FC_FULL);
        // thresholds only meaningful when we may send pause
        low_o   <= tx_sel ? low_i  : '0;
        high_o  <= tx_sel ? high_i : '0;
        xon_o   <= tx_sel & xon_i;
      end
    end
  end
endmodule

// File: rtl/pause_fc_resolver.sv
module pause_fc_resolver
  import fcr_pkg::*;
#(
  parameter int WM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             resolve_i,
  input  logic             an_enable_i,
  input  logic             an_complete_i,
  input  logic             loc_pause_i,
  input  logic             loc_asym_i,
  input  logic             lp_pause_i,
  input  logic             lp_asym_i,
  input  logic [REQ_W-1:0] req_mode_i,
  input  logic             full_duplex_i,
  input  logic [WM_W-1:0]  low_water_i,
  input  logic [WM_W-1:0]  high_water_i,
  input  logic             send_xon_i,
  output logic [1:0]       mode_o,
  output logic             tx_pause_en_o,
  output logic             rx_pause_en_o,
  output logic [WM_W-1:0]  low_thr_o,
  output logic [WM_W-1:0]  high_thr_o,
  output logic             xon_en_o,
  output logic             done_o,
  output logic             cfg_err_o
);
  fc_mode_e neg_mode, frc_mode, sel_mode, fin_mode, cur_mode;
  logic     frc_bad, want_full, apply, err_set;

  assign want_full = (req_mode_i == REQ_FULL) || (req_mode_i == REQ_DFLT);

  fcr_negotiate u_neg (
    .loc_pause_i (loc_pause_i),
    .loc_asym_i  (loc_asym_i),
    .lp_pause_i  (lp_pause_i),
    .lp_asym_i   (lp_asym_i),
    .want_full_i (want_full),
    .mode_o      (neg_mode)
  );

  fcr_force_decode u_frc (
    .req_i  (req_mode_i),
    .mode_o (frc_mode),
    .bad_o  (frc_bad)
  );

  assign sel_mode = an_enable_i ? neg_mode : frc_mode;
  assign fin_mode = full_duplex_i ? sel_mode : FC_NONE;
  assign apply    = resolve_i && (an_enable_i ? an_complete_i : !frc_bad);
  assign err_set  = resolve_i && !an_enable_i && frc_bad;

  fcr_state #(.WM_W(WM_W)) u_st (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (resolve_i),
    .apply_i   (apply),
    .err_set_i (err_set),
    .mode_i    (fin_mode),
    .low_i     (low_water_i),
    .high_i    (high_water_i),
    .xon_i     (send_xon_i),
    .mode_o    (cur_mode),
    .tx_en_o   (tx_pause_en_o),
    .rx_en_o   (rx_pause_en_o),
    .low_o     (low_thr_o),
    .high_o    (high_thr_o),
    .xon_o     (xon_en_o),
    .done_o    (done_o),
    .err_o     (cfg_err_o)
  );

  assign mode_o = cur_mode;
endmodule

// File: rtl/fcr_checker.sv
module fcr_checker #(
  parameter int WM_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            resolve_i,
  input logic            an_enable_i,
  input logic            an_complete_i,
  input logic            loc_pause_i,
  input logic            lp_pause_i,
  input logic            full_duplex_i,
  input logic [1:0]      mode_o,
  input logic            tx_pause_en_o,
  input logic            rx_pause_en_o,
  input logic [WM_W-1:0] high_thr_o,
  input logic            done_o,
  input logic            cfg_err_o
);
  AST_ENABLES_TRACK_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pause_en_o == mode_o[1]) && (rx_pause_en_o == mode_o[0])); // R1
  AST_SYM_RECEIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i && an_enable_i && an_complete_i && full_duplex_i && loc_pause_i && lp_pause_i
    |=> rx_pause_en_o); // R2
  AST_HALF_DUPLEX_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i && an_enable_i && an_complete_i && !full_duplex_i |=> mode_o == 2'd0); // R6
  AST_AN_PENDING_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i && an_enable_i && !an_complete_i |=> $stable(mode_o)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R9
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i |=> done_o); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resolve_i |=> $stable(mode_o) && !done_o); // R10
  AST_WM_ZERO_NO_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_pause_en_o |-> high_thr_o == '0); // R11
endmodule

bind pause_fc_resolver fcr_checker #(.WM_W(WM_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .resolve_i     (resolve_i),
  .an_enable_i   (an_enable_i),
  .an_complete_i (an_complete_i),
  .loc_pause_i   (loc_pause_i),
  .lp_pause_i    (lp_pause_i),
  .full_duplex_i (full_duplex_i),
  .mode_o        (mode_o),
  .tx_pause_en_o (tx_pause_en_o),
  .rx_pause_en_o (rx_pause_en_o),
  .high_thr_o    (high_thr_o),
  .done_o        (done_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/pause_fc_resolver_tb_top.sv
module pause_fc_resolver_tb_top;
  localparam int WM_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resolve = 1'b0, an_en = 1'b0, an_cmp = 1'b0;
  logic lp = 1'b0, la = 1'b0, pp = 1'b0, pa = 1'b0, fd = 1'b0, xon = 1'b0;
  logic [2:0] req = '0;
  logic [WM_W-1:0] lw = '0, hw = '0;
  logic [1:0] mode;
  logic tx_en, rx_en, xon_o, done, err;
  logic [WM_W-1:0] low_o, high_o;

  int n_run = 0, n_fail = 0;
  logic [1:0] e_mode = 2'd0;
  logic [WM_W-1:0] e_low = '0, e_high = '0;
  logic e_xon = 1'b0, e_err = 1'b0;

  always #2 clk = ~clk;

  pause_fc_resolver #(.WM_W(WM_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .resolve_i(resolve), .an_enable_i(an_en),
    .an_complete_i(an_cmp), .loc_pause_i(lp), .loc_asym_i(la), .lp_pause_i(pp),
    .lp_asym_i(pa), .req_mode_i(req), .full_duplex_i(fd), .low_water_i(lw),
    .high_water_i(hw), .send_xon_i(xon), .mode_o(mode), .tx_pause_en_o(tx_en),
    .rx_pause_en_o(rx_en), .low_thr_o(low_o), .high_thr_o(high_o), .xon_en_o(xon_o),
    .done_o(done), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic e_done);
    chk(mode == e_mode, tag, "mode", 32'(mode), 32'(e_mode));
    chk(tx_en == e_mode[1] && rx_en == e_mode[0], tag, "enables (R1)",
        32'({tx_en, rx_en}), 32'(e_mode));
    chk(low_o == e_low && high_o == e_high && xon_o == e_xon, tag, "watermarks (R11)",
        {low_o, high_o[14:0], xon_o}, {e_low, e_high[14:0], e_xon});
    chk(done == e_done, tag, "done (R10)", 32'(done), 32'(e_done));
    chk(err == e_err, tag, "cfg_err (R9)", 32'(err), 32'(e_err));
  endtask

  // independent model of the requirements
  task automatic model;
    logic [1:0] m;
    bit ap;
    bit wf;
    m = 2'd0; ap = 0;
    wf = (req == 3'd3) || (req == 3'd4);
    if (an_en) begin
      if (an_cmp) begin
        ap = 1;
        if (lp && pp)                 m = wf ? 2'd3 : 2'd1;  // R2
        else if (!lp && la && pp && pa) m = 2'd2;            // R3
        else if (lp && la && !pp && pa) m = 2'd1;            // R4
        else                          m = 2'd0;              // R5
      end
    end else begin
      if (req <= 3'd3)      begin m = req[1:0]; ap = 1; end  // R8
      else if (req == 3'd4) begin m = 2'd3; ap = 1; end
      else e_err = 1'b1;                                     // R9
    end
    if (ap && !fd) m = 2'd0;                                 // R6
    if (ap) begin
      e_mode = m;
      e_low  = m[1] ? lw : '0;
      e_high = m[1] ? hw : '0;
      e_xon  = m[1] & xon;
    end
  endtask

  task automatic strobe(input bit a_en, input bit a_cmp, input bit l_p, input bit l_a,
                        input bit p_p, input bit p_a, input logic [2:0] rq, input bit f_d,
                        input string tag);
    @(negedge clk);
    an_en = a_en; an_cmp = a_cmp; lp = l_p; la = l_a; pp = p_p; pa = p_a;
    req = rq; fd = f_d; lw = 16'($urandom); hw = 16'($urandom); xon = 1'($urandom);
    resolve = 1'b1;
    model();
    @(negedge clk);
    resolve = 1'b0;
    check_all(tag, 1'b1);
  endtask

  initial begin
    #40000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk);
    check_all("R12", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R12", 1'b0);

    strobe(1,1, 1,0,1,0, 3'd3, 1, "R2");  // full requested
    strobe(1,1, 1,1,1,1, 3'd4, 1, "R2");  // default -> full
    strobe(1,1, 1,0,1,0, 3'd1, 1, "R2");  // not full -> rx only
    strobe(1,1, 0,1,1,1, 3'd3, 1, "R3");
    strobe(1,1, 1,1,0,1, 3'd3, 1, "R4");
    strobe(1,1, 1,1,0,0, 3'd3, 1, "R5");
    strobe(1,1, 0,1,1,0, 3'd3, 1, "R5");
    strobe(1,1, 1,1,1,1, 3'd3, 0, "R6");  // half duplex
    strobe(0,0, 0,0,0,0, 3'd3, 1, "R8");
    strobe(1,0, 0,1,1,1, 3'd2, 1, "R7");  // AN not complete: held
    strobe(0,0, 0,0,0,0, 3'd2, 1, "R8");
    strobe(0,0, 0,0,0,0, 3'd4, 1, "R8");
    strobe(0,0, 0,0,0,0, 3'd2, 0, "R6");
    strobe(0,0, 0,0,0,0, 3'd1, 1, "R1");
    @(negedge clk);
    check_all("R10", 1'b0);             // idle cycle holds
    strobe(0,0, 0,0,0,0, 3'd6, 1, "R9"); // invalid forced code
    strobe(1,1, 0,1,1,1, 3'd0, 1, "R9"); // flag stays

    for (int i = 0; i < 300; i++) begin
      strobe(1'($urandom), ($urandom_range(0,3) != 0), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom), 3'($urandom_range(0,7)),
             ($urandom_range(0,3) != 0), "R1-random");
      if (($urandom & 3) == 0) begin
        @(negedge clk);
        check_all("R10", 1'b0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule